// File: doc/BRIEF.md
# Selectable PLL Reference Divider

The block turns a 75 kHz crystal clock into the reference tick for a PLL phase comparator. A 4-bit select register chooses one of ten division ratios (75, 54, 48, 27, 25, 24, 15, 12, 6 or 3). These give reference rates from 1 kHz up to 25 kHz. The reference leaves the block as a train of one-clock-wide pulses, with one pulse at the end of each divide period.

Software writes the select register through a single-cycle write strobe. Every write does two things. It restarts the divide period from zero. It also issues a one-cycle reload strobe, which tells the programmable main counter to move its pending division value into its active register. Software must therefore set up the division value before it writes the select code.

The select codes that map to no ratio shut the PLL down. These are the six codes 0xA to 0xF, and 0xF is the code loaded at reset. In this off state the divider halts and stop signals are asserted toward the programmable counter, the IF counter and the phase comparator. An inhibit input, gated by an enable input, can force the same off state.

Top module: `refdiv_top`

## Requirements
- R1: After reset the select register holds 0xF. All three stop outputs are 1 and `ref_pulse` stays 0 until a valid code is written.
- R2: Select codes 0 to 9 give divide periods of 75, 54, 48, 27, 25, 24, 15, 12, 6 and 3 clocks, in that order. `ref_pulse` is high for exactly one clock in each period.
- R3: A write restarts the divider. If the write strobe is sampled at clock edge E0, the first pulse of the new code is high in the cycle that follows edge E0+N, where N is the new code's period. The next pulse follows edge E0+2N.
- R4: Select codes 0xA to 0xF are off codes. While one is held, all three stop outputs are 1 and `ref_pulse` is 0.
- R5: Every write, whatever the code, makes `pcnt_reload` high for exactly the one cycle that follows the write edge. `pcnt_reload` is 0 at all other times.
- R6: While `inh_en` is 1 and `inh_pin` is 1, the block is off in the same way as in R4, even with a valid code. While `inh_en` is 0, `inh_pin` has no effect on the outputs.
- R7: `pcnt_stop`, `ifc_stop` and `cmp_stop` are all 0 while a valid code is held and no inhibit is in force.

Each stop output is 1 while the block is off, as R1, R4 and R6 define.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 75 kHz crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Single-cycle write strobe for the select register |
| sel_wdata | input | 4 | Select code to be written |
| inh_en | input | 1 | Allows `inh_pin` to force the off state |
| inh_pin | input | 1 | External inhibit input, active high |
| ref_pulse | output | 1 | One-clock-wide reference pulse |
| pcnt_reload | output | 1 | Load strobe for the main counter's division value |
| pcnt_stop | output | 1 | Stop signal to the programmable counter |
| ifc_stop | output | 1 | Stop signal to the IF counter |
| cmp_stop | output | 1 | Stop signal to the phase comparator |

## Verification
The bench builds the block with its default widths: a 4-bit select code and a 7-bit counter sized for the largest ratio of 75. At these widths every one of the sixteen codes can be applied. The first and second pulse positions can be measured for each ratio, from the longest period of 75 clocks down to the shortest period of 3 clocks. All six off codes are covered as well. Directed cases cover the following:
- a rewrite part-way through a period;
- a write while the block is off;
- the inhibit input both with and without its enable.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int SEL_W     = 4;
  localparam int MAX_RATIO = 75;
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  // Divide ratio for a select code; zero marks an off code.
  function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      4'd0:    r = CNT_W'(75);
      4'd1:    r = CNT_W'(54);
      4'd2:    r = CNT_W'(48);
      4'd3:    r = CNT_W'(27);
      4'd4:    r = CNT_W'(25);
      4'd5:    r = CNT_W'(24);
      4'd6:    r = CNT_W'(15);
      4'd7:    r = CNT_W'(12);
      4'd8:    r = CNT_W'(6);
      4'd9:    r = CNT_W'(3);
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/refsel_reg.sv
module refsel_reg #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic             reload_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '1;
      reload_q <= 1'b0;
    end else begin
      reload_q <= sel_wr;
      if (sel_wr) sel_q <= sel_wdata;
    end
  end

  assert_reload_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> reload_q);
  assert_reload_only_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q |-> $past(sel_wr));
endmodule

// File: rtl/ref_counter.sv
module ref_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             off,
  input  logic [CNT_W-1:0] ratio,
  output logic             ref_pulse,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt;
  logic             pulse_q;

  assign wrap = (cnt == ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pulse_q <= 1'b0;
    end else if (restart || off) begin
      cnt     <= '0;
      pulse_q <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      pulse_q <= 1'b1;
    end else begin
      cnt     <= cnt + 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign ref_pulse = pulse_q & ~off;

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !off |-> (cnt < ratio));
  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (cnt == '0));
  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> !ref_pulse);
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic [SW-1:0] sel_wdata,
  input  logic          inh_en,
  input  logic          inh_pin,
  output logic          ref_pulse,
  output logic          pcnt_reload,
  output logic          pcnt_stop,
  output logic          ifc_stop,
  output logic          cmp_stop
);
  logic [SW-1:0] sel_q;
  logic [CW-1:0] ratio;
  logic          code_off, inh_off, pll_off, wrap;

  refsel_reg #(.SEL_W(SW)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .sel_q(sel_q), .reload_q(pcnt_reload)
  );

  assign ratio    = CW'(ratio_of(SEL_W'(sel_q)));
  assign code_off = (ratio == '0);
  assign inh_off  = inh_en & inh_pin;
  assign pll_off  = code_off | inh_off;

  ref_counter #(.CNT_W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(sel_wr), .off(pll_off),
    .ratio(ratio), .ref_pulse(ref_pulse), .wrap(wrap)
  );

  assign pcnt_stop = pll_off;
  assign ifc_stop  = pll_off;
  assign cmp_stop  = pll_off;

  assert_inhibit_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inh_off |-> (!ref_pulse && cmp_stop));
  assert_run_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> (!pcnt_stop && !ifc_stop));
endmodule

// File: tb/refdiv_top_tb.sv
`timescale 1ns/1ps
module refdiv_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_wr = 1'b0;
  logic [3:0] sel_wdata = 4'h0;
  logic       inh_en = 1'b0;
  logic       inh_pin = 1'b0;
  logic       ref_pulse, pcnt_reload, pcnt_stop, ifc_stop, cmp_stop;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam int EXP_RATIO [16] = '{75, 54, 48, 27, 25, 24, 15, 12, 6, 3, 0, 0, 0, 0, 0, 0};

  always #4 clk = ~clk;

  refdiv_top u_dut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .inh_en(inh_en), .inh_pin(inh_pin), .ref_pulse(ref_pulse),
    .pcnt_reload(pcnt_reload), .pcnt_stop(pcnt_stop), .ifc_stop(ifc_stop),
    .cmp_stop(cmp_stop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write a code; returns at the negedge after the write edge, checking R5.
  task automatic write_code(input logic [3:0] code);
    @(negedge clk);
    sel_wr = 1'b1;
    sel_wdata = code;
    @(posedge clk);
    @(negedge clk);
    sel_wr = 1'b0;
    check(pcnt_reload == 1'b1, "R5 reload after write", int'(pcnt_reload), 1);
  endtask

  // Watch up to lim cycles after the write edge; report first/second pulse index.
  task automatic measure(input int lim, output int first, output int second,
                         output int wide, output int stop_bad, output int rl_late);
    first = 0; second = 0; wide = 0; stop_bad = 0; rl_late = 0;
    for (int k = 1; k <= lim; k++) begin
      logic prev;
      prev = ref_pulse;
      @(posedge clk);
      @(negedge clk);
      if (pcnt_reload) rl_late++;
      if (ref_pulse && prev) wide++;
      if (ref_pulse) begin
        if (first == 0) first = k;
        else if (second == 0) second = k;
      end
      if (pcnt_stop || ifc_stop || cmp_stop) stop_bad++;
    end
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int f, s, w, sb, rl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state is off
    check(pcnt_stop && ifc_stop && cmp_stop, "R1 stops after reset",
          int'({pcnt_stop, ifc_stop, cmp_stop}), 7);
    begin
      int seen = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (ref_pulse || pcnt_reload) seen++;
      end
      check(seen == 0, "R1 no pulse after reset", seen, 0);
    end

    // Vector table: R2, R3, R4, R7
    for (int c = 0; c < 16; c++) begin
      write_code(4'(c));
      if (EXP_RATIO[c] != 0) begin
        measure(2 * EXP_RATIO[c] + 1, f, s, w, sb, rl);
        check(f == EXP_RATIO[c], "R3 first pulse position", f, EXP_RATIO[c]);
        check(s == 2 * EXP_RATIO[c], "R2 period", s - f, EXP_RATIO[c]);
        check(w == 0, "R2 pulse width one clock", w, 0);
        check(sb == 0, "R7 stops low while running", sb, 0);
        check(rl == 0, "R5 reload single cycle", rl, 0);
      end else begin
        measure(100, f, s, w, sb, rl);
        check(f == 0, "R4 off code silent", f, 0);
        check(sb == 100, "R4 stops high for off code", sb, 100);
      end
    end

    // R3: rewrite mid-period restarts the count
    write_code(4'd6);
    repeat (7) @(negedge clk);
    write_code(4'd6);
    measure(31, f, s, w, sb, rl);
    check(f == 15, "R3 restart mid-period", f, 15);

    // R5: write while off still pulses reload once
    write_code(4'hF);
    measure(5, f, s, w, sb, rl);
    check(rl == 0 && f == 0, "R5 reload once in off write", rl, 0);

    // R6: inhibit with enable forces off
    write_code(4'd9);
    inh_en = 1'b1;
    inh_pin = 1'b1;
    measure(20, f, s, w, sb, rl);
    check(f == 0, "R6 inhibit silences pulse", f, 0);
    check(sb == 20, "R6 inhibit raises stops", sb, 20);
    inh_pin = 1'b0;
    @(negedge clk);
    measure(12, f, s, w, sb, rl);
    check(f != 0 && sb == 0, "R6 release resumes", f, 1);

    // R6: pin ignored while enable is low
    inh_en = 1'b0;
    inh_pin = 1'b1;
    write_code(4'd9);
    measure(7, f, s, w, sb, rl);
    check(f == 3 && s == 6, "R6 pin ignored without enable", f, 3);
    check(sb == 0, "R7 stops low with disabled inhibit", sb, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule